// File: doc/BRIEF.md
# Vectored Interrupt Dispatch Controller

This block decides, when the processor asks, whether an interrupt should be taken. If so, it hands control to the handler of the chosen channel. It holds a 16-bit pending register that request pulses set. The top bit of that register is a global disable flag. When a check strobe arrives, the block first looks at the pending register. An empty register, or one with the disable bit set, is treated as a false alarm, and execution resumes at the current program counter.

Otherwise the controller runs a fixed sequence on a word-addressed memory port. It reads a parked waiting word and an enable mask, and merges the waiting word into the pending register. It then looks for a channel that is both pending and enabled. If it finds none, the merged bits are parked back in memory and execution resumes. If it finds one, the controller saves the current program counter to a fixed location and picks the lowest-numbered candidate. It fetches that channel's handler address from a vector table, parks the remaining bits, and disables further interrupts. Finally it issues the handler address with a load strobe.

Top module: `vec_irq_dispatch`

## Requirements
- R1: After reset, busy_o, resume_o, pc_load_o and mem_req_o are all low, and the pending register is zero.
- R2: If the pending register is zero, or has bit 15 set, when check_i is taken, the block makes no memory access. It pulses resume_o with new_pc_o equal to the cur_pc_i value that was sampled with check_i.
- R3: A check that is not a false alarm first reads the waiting word at octal address 452 and then the enable mask at octal 453. Each request holds its address and direction until mem_ready_i is high at a clock edge.
- R4: If (pending OR waiting) AND mask is zero, the block writes the merged value (pending OR waiting) to octal 452. It then clears the pending register and pulses resume_o with the sampled PC.
- R5: If some channel is both pending and enabled, the block writes the sampled PC to octal 500 before any vector read.
- R6: The chosen channel is the lowest set bit position i of (pending OR waiting) AND mask. The vector word is read from octal 501 plus i.
- R7: After the vector read, the block writes the merged value with bit i cleared to octal 452.
- R8: After a dispatch, pc_load_o pulses with new_pc_o equal to the vector word. The pending register then holds 0x8000, so the next check is a false alarm.
- R9: A request pulse on irq_set_i is never lost. This holds in the cycle where the sequence reloads the pending register: the set bit wins over the update.
- R10: busy_o is high from the cycle after a taken check through the cycle of the single resume_o or pc_load_o pulse, and low afterwards. check_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| check_i | input | 1 | Request to test for a takeable interrupt |
| cur_pc_i | input | DW | Program counter at the time of the check |
| irq_set_i | input | DW | One-cycle request pulses, one bit per channel |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Word address |
| mem_wdata_o | output | DW | Write data |
| mem_ready_i | input | 1 | Access completes at this edge |
| mem_rdata_i | input | DW | Read data, valid with mem_ready_i |
| busy_o | output | 1 | Check sequence in progress |
| resume_o | output | 1 | One-cycle pulse: continue at new_pc_o without dispatch |
| pc_load_o | output | 1 | One-cycle pulse: load new_pc_o as handler address |
| new_pc_o | output | DW | Program counter to continue from |

## Verification
The bench keeps the default DW=16 and AW=16 with the standard table addresses. This makes every priority position from 0 to 15 reachable, including bit 15, which is pending through the parked word while also acting as the disable flag. The sweep covers each lowest-bit position and a set of arithmetically generated pending, waiting and mask words. Memory latency varies from zero to two wait cycles. Injected request pulses land both mid-sequence and exactly on the register reload edges.

// File: rtl/irq_disp_pkg.sv
package irq_disp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_WAIT,
    ST_RD_ACT,
    ST_WR_PARK,
    ST_WR_PC,
    ST_RD_VEC,
    ST_WR_REST,
    ST_RESUME,
    ST_LOAD
  } disp_st_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] set_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] pend_o
);

  logic [DW-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= (ld_i ? ld_val_i : pend_q) | set_i;
  end

  assign pend_o = pend_q;

  // R9: a request bit is present one cycle after its pulse
  p_set_kept_r9: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((pend_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
  parameter int DW = 16,
  localparam int IW = $clog2(DW)
) (
  input  logic [DW-1:0] hit_i,
  output logic          valid_o,
  output logic [DW-1:0] onehot_o,
  output logic [IW-1:0] idx_o
);

  logic [DW:0] below;

  assign below[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : g_scan
      assign below[g+1]  = below[g] | hit_i[g];
      assign onehot_o[g] = hit_i[g] & ~below[g];
    end
  endgenerate

  assign valid_o = below[DW];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < DW; k++) begin
      if (onehot_o[k]) idx_o = IW'(k);
    end
  end

  // R6: the pick is a single candidate bit with no candidate below it
  always_comb begin
    if (hit_i != '0) begin
      p_pick_lowest_r6: assert ($onehot(onehot_o) && ((onehot_o & hit_i) != '0)
                                && (((onehot_o - 1'b1) & hit_i) == '0));
    end
  end

endmodule

// File: rtl/vec_irq_dispatch.sv
module vec_irq_dispatch
  import irq_disp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 16,
  parameter logic [AW-1:0] WAIT_ADDR = AW'(9'o452),
  parameter logic [AW-1:0] MASK_ADDR = AW'(9'o453),
  parameter logic [AW-1:0] SAVE_ADDR = AW'(9'o500),
  parameter logic [AW-1:0] VEC_BASE  = AW'(9'o501)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          check_i,
  input  logic [DW-1:0] cur_pc_i,
  input  logic [DW-1:0] irq_set_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          resume_o,
  output logic          pc_load_o,
  output logic [DW-1:0] new_pc_o
);

  localparam int IW = $clog2(DW);
  localparam logic [DW-1:0] OFF_WORD = {1'b1, {(DW-1){1'b0}}};

  disp_st_e      st_q, st_d;
  logic [DW-1:0] pc_q;
  logic [DW-1:0] merged_q;
  logic [DW-1:0] hit_q;
  logic [DW-1:0] pend_q;
  logic          pend_ld;
  logic [DW-1:0] pend_val;
  logic          pick_vld;
  logic [DW-1:0] pick_oh;
  logic [IW-1:0] pick_idx;
  logic          xfer;

  irq_pend_reg #(.DW(DW)) i_pend (
    .clk      (clk),
    .rst      (rst),
    .set_i    (irq_set_i),
    .ld_i     (pend_ld),
    .ld_val_i (pend_val),
    .pend_o   (pend_q)
  );

  irq_lsb_pick #(.DW(DW)) i_pick (
    .hit_i    (hit_q),
    .valid_o  (pick_vld),
    .onehot_o (pick_oh),
    .idx_o    (pick_idx)
  );

  assign xfer = mem_req_o & mem_ready_i;

  // next state
  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:    if (check_i) st_d = ($signed(pend_q) > 0) ? ST_RD_WAIT : ST_RESUME;
      ST_RD_WAIT: if (mem_ready_i) st_d = ST_RD_ACT;
      ST_RD_ACT:  if (mem_ready_i)
                    st_d = ((pend_q & mem_rdata_i) == '0) ? ST_WR_PARK : ST_WR_PC;
      ST_WR_PARK: if (mem_ready_i) st_d = ST_RESUME;
      ST_WR_PC:   if (mem_ready_i) st_d = ST_RD_VEC;
      ST_RD_VEC:  if (mem_ready_i) st_d = ST_WR_REST;
      ST_WR_REST: if (mem_ready_i) st_d = ST_LOAD;
      ST_RESUME:  st_d = ST_IDLE;
      ST_LOAD:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // memory port decode
  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    case (st_q)
      ST_RD_WAIT: begin mem_req_o = 1'b1; mem_addr_o = WAIT_ADDR; end
      ST_RD_ACT:  begin mem_req_o = 1'b1; mem_addr_o = MASK_ADDR; end
      ST_WR_PARK: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = WAIT_ADDR; mem_wdata_o = merged_q;
      end
      ST_WR_PC: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = SAVE_ADDR; mem_wdata_o = pc_q;
      end
      ST_RD_VEC: begin
        mem_req_o = 1'b1;
        mem_addr_o = VEC_BASE + AW'(pick_idx);
      end
      ST_WR_REST: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1;
        mem_addr_o = WAIT_ADDR; mem_wdata_o = merged_q & ~pick_oh;
      end
      default: ;
    endcase
  end

  // pending register updates, only on completed accesses
  always_comb begin
    pend_ld  = 1'b0;
    pend_val = pend_q;
    if (xfer) begin
      case (st_q)
        ST_RD_WAIT: begin pend_ld = 1'b1; pend_val = pend_q | mem_rdata_i; end
        ST_RD_ACT:  if ((pend_q & mem_rdata_i) == '0) begin
                      pend_ld = 1'b1; pend_val = '0;
                    end
        ST_WR_REST: begin pend_ld = 1'b1; pend_val = OFF_WORD | (pend_q & ~merged_q); end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pc_q     <= '0;
      merged_q <= '0;
      hit_q    <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && check_i) pc_q <= cur_pc_i;
      if (st_q == ST_RD_ACT && mem_ready_i) begin
        merged_q <= pend_q;
        hit_q    <= pend_q & mem_rdata_i;
      end
      if (st_q == ST_RD_VEC && mem_ready_i) pc_q <= mem_rdata_i;
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign resume_o  = (st_q == ST_RESUME);
  assign pc_load_o = (st_q == ST_LOAD);
  assign new_pc_o  = pc_q;

  // R10: one completion pulse, then idle
  p_one_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    (resume_o | pc_load_o) |-> (busy_o && $onehot0({resume_o, pc_load_o})));
  p_idle_after_r10: assert property (@(posedge clk) disable iff (rst)
    (resume_o | pc_load_o) |=> !busy_o);
  // R3: an outstanding request is held unchanged
  p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req_o && !mem_ready_i) |=>
      (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));
  // R8: handler load leaves interrupts disabled
  p_off_at_load_r8: assert property (@(posedge clk) disable iff (rst)
    pc_load_o |-> pend_q[DW-1]);
  // R6: vector reads stay inside the table and only with a valid pick
  p_vec_range_r6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RD_VEC) |-> (pick_vld && mem_addr_o >= VEC_BASE
                             && mem_addr_o < VEC_BASE + AW'(DW)));
  // R2: no memory traffic outside a busy sequence
  p_quiet_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);

endmodule

// File: tb/test_vec_irq_dispatch.sv
module test_vec_irq_dispatch;

  localparam int DW = 16;
  localparam int AW = 16;
  localparam logic [AW-1:0] A_WAIT = 16'o452;
  localparam logic [AW-1:0] A_MASK = 16'o453;
  localparam logic [AW-1:0] A_SAVE = 16'o500;
  localparam logic [AW-1:0] A_VEC  = 16'o501;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          check = 1'b0;
  logic [DW-1:0] cur_pc = '0;
  logic [DW-1:0] irq = '0;
  logic          mem_req_o, mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic          mem_ready = 1'b0;
  logic [DW-1:0] mem_rdata = '0;
  logic          busy_o, resume_o, pc_load_o;
  logic [DW-1:0] new_pc_o;

  always #2 clk = ~clk;

  vec_irq_dispatch #(.DW(DW), .AW(AW)) i_vec_irq_dispatch (
    .clk(clk), .rst(rst), .check_i(check), .cur_pc_i(cur_pc), .irq_set_i(irq),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready), .mem_rdata_i(mem_rdata),
    .busy_o(busy_o), .resume_o(resume_o), .pc_load_o(pc_load_o), .new_pc_o(new_pc_o)
  );

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0] mem [0:511];
  logic [AW-1:0] la [0:15];
  logic          lw [0:15];
  logic [DW-1:0] ldat [0:15];
  int ln = 0;
  int lat = 0;
  int wcnt = 0;

  // memory model: ready after lat wait cycles, logs each committed access
  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0; wcnt = 0;
    end else if (mem_req_o) begin
      if (wcnt >= lat) begin
        mem_ready = 1'b1;
        if (mem_we_o) mem[mem_addr_o[8:0]] = mem_wdata_o;
        else          mem_rdata = mem[mem_addr_o[8:0]];
        if (ln < 16) begin
          la[ln]   = mem_addr_o;
          lw[ln]   = mem_we_o;
          ldat[ln] = mem_we_o ? mem_wdata_o : mem_rdata;
        end
        ln++;
      end else begin
        wcnt++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_log(input int n, input logic [AW-1:0] a, input logic w,
                         input logic [DW-1:0] d, input string tag);
    chk(la[n] == a && lw[n] == w && ldat[n] == d, tag,
        {la[n][14:0], lw[n], ldat[n]}, {a[14:0], w, d});
  endtask

  function automatic logic [DW-1:0] vec_of(input int i);
    return 16'hA000 ^ DW'(i * 16'h0123);
  endfunction

  task automatic do_reset();
    rst = 1'b1; irq = '0; check = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !resume_o && !pc_load_o && !mem_req_o, "R1 reset outputs",
        {busy_o, resume_o, pc_load_o, mem_req_o}, 0);
  endtask

  task automatic run_check(input logic [DW-1:0] pc, input bit dbl, output bit g_res,
                           output bit g_ld, output logic [DW-1:0] g_pc, output bit b_ok);
    g_res = 0; g_ld = 0; g_pc = '0; b_ok = 1;
    @(negedge clk); cur_pc = pc; check = 1'b1;
    @(negedge clk); check = 1'b0;
    for (int c = 0; c < 300; c++) begin
      if (!busy_o) b_ok = 0;
      if (resume_o || pc_load_o) begin
        g_res = resume_o; g_ld = pc_load_o; g_pc = new_pc_o;
        break;
      end
      check = (dbl && c == 2);
      @(negedge clk);
    end
    check = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      if (busy_o || resume_o || pc_load_o) b_ok = 0;
    end
  endtask

  task automatic inject(input logic [AW-1:0] a, input logic w, input logic [DW-1:0] v);
    for (int c = 0; c < 100; c++) begin
      @(negedge clk); #1;
      if (mem_ready && mem_req_o && mem_addr_o == a && mem_we_o == w) begin
        irq = v;
        @(negedge clk);
        irq = '0;
        break;
      end
    end
  endtask

  task automatic run_case(input logic [DW-1:0] pend, input logic [DW-1:0] ww,
                          input logic [DW-1:0] act, input logic [DW-1:0] pc,
                          input int l, input bit dbl);
    bit r, ldd, bok;
    logic [DW-1:0] gp, merged, hit;
    int idx;
    do_reset();
    for (int i = 0; i < 512; i++) mem[i] = 16'hFFFF;
    mem[A_WAIT[8:0]] = ww;
    mem[A_MASK[8:0]] = act;
    for (int i = 0; i < DW; i++) mem[A_VEC[8:0] + 9'(i)] = vec_of(i);
    lat = l;
    @(negedge clk); irq = pend;
    @(negedge clk); irq = '0;
    ln = 0;
    run_check(pc, dbl, r, ldd, gp, bok);
    chk(bok, "R10 busy window", {31'd0, bok}, 1);
    merged = pend | ww;
    hit = merged & act;
    if ($signed(pend) <= 0) begin
      chk(r && !ldd && gp == pc, "R2 false alarm resumes at pc", {r, ldd, 14'd0, gp}, {2'b10, 14'd0, pc});
      chk(ln == 0, "R2 no memory access", ln, 0);
    end else if (hit == '0) begin
      chk(ln == 3, "R4 access count", ln, 3);
      chk_log(0, A_WAIT, 1'b0, ww, "R3 first read waiting word");
      chk_log(1, A_MASK, 1'b0, act, "R3 second read mask");
      chk_log(2, A_WAIT, 1'b1, merged, "R4 park merged");
      chk(r && !ldd && gp == pc, "R4 resume at pc", {r, ldd, 14'd0, gp}, {2'b10, 14'd0, pc});
    end else begin
      idx = 0;
      for (int k = DW - 1; k >= 0; k--) if (hit[k]) idx = k;
      chk(ln == 5, "R5 access count", ln, 5);
      chk_log(0, A_WAIT, 1'b0, ww, "R3 first read waiting word");
      chk_log(1, A_MASK, 1'b0, act, "R3 second read mask");
      chk_log(2, A_SAVE, 1'b1, pc, "R5 save pc before vector");
      chk_log(3, A_VEC + AW'(idx), 1'b0, vec_of(idx), "R6 vector of lowest channel");
      chk_log(4, A_WAIT, 1'b1, merged & ~(DW'(1) << idx), "R7 park remaining");
      chk(ldd && !r && gp == vec_of(idx), "R8 load handler", {r, ldd, 14'd0, gp},
          {2'b01, 14'd0, vec_of(idx)});
      ln = 0;
      run_check(pc ^ 16'h00FF, 1'b0, r, ldd, gp, bok);
      chk(r && !ldd && ln == 0 && gp == (pc ^ 16'h00FF), "R8 disabled after dispatch",
          {r, ldd, 6'd0, 8'(ln), gp}, {2'b10, 14'd0, pc ^ 16'h00FF});
    end
  endtask

  initial begin
    bit r, ldd, bok;
    logic [DW-1:0] gp;

    // explicit corners
    run_case(16'h0000, 16'h0003, 16'hFFFF, 16'h1234, 0, 0);   // R2 empty
    run_case(16'h8001, 16'h0000, 16'hFFFF, 16'h2345, 1, 0);   // R2 sign set
    run_case(16'h0010, 16'h0100, 16'h0000, 16'h3456, 2, 0);   // R4 none enabled
    run_case(16'h0001, 16'h8000, 16'h8000, 16'h4567, 1, 0);   // R6 bit 15 via waiting word
    run_case(16'h0020, 16'h0000, 16'hFFFF, 16'h5678, 2, 1);   // R10 check while busy

    // R6: every priority position
    for (int i = 0; i < DW - 1; i++)
      run_case((DW'(1) << i) | 16'h4000, DW'(i * 16'h0101) & 16'h7FFF,
               16'hFFFF << i, DW'(16'h0400 + i), i % 3, 0);

    // generated mix
    for (int k = 0; k < 24; k++)
      run_case(DW'(k * 16'h1357) ^ 16'h2468, DW'(k * 16'h00F1),
               ~DW'(k * 16'h3A1), DW'(16'h7000 + k * 3), k % 3, 0);

    // R9: pulses during a no-enable pass, one on the reload edge, are kept
    do_reset();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    lat = 2;
    @(negedge clk); irq = 16'h0001;
    @(negedge clk); irq = '0;
    ln = 0;
    fork
      run_check(16'h0ABC, 1'b0, r, ldd, gp, bok);
      inject(A_MASK, 1'b0, 16'h0010);
    join
    chk(r && ln == 3 && ldat[2] == 16'h0001, "R9 first park", {r, 7'd0, 8'(ln), ldat[2]}, {8'h80, 8'd3, 16'h0001});
    ln = 0;
    run_check(16'h0ABD, 1'b0, r, ldd, gp, bok);
    chk(r && ln == 3 && ldat[2] == 16'h0011, "R9 pulse on reload edge kept",
        {r, 7'd0, 8'(ln), ldat[2]}, {8'h80, 8'd3, 16'h0011});

    // R9: pulse on the waiting-word read edge joins the candidate set
    do_reset();
    for (int i = 0; i < 512; i++) mem[i] = '0;
    mem[A_MASK[8:0]] = 16'hFFFF;
    for (int i = 0; i < DW; i++) mem[A_VEC[8:0] + 9'(i)] = vec_of(i);
    lat = 1;
    @(negedge clk); irq = 16'h0100;
    @(negedge clk); irq = '0;
    ln = 0;
    fork
      run_check(16'h0DEF, 1'b0, r, ldd, gp, bok);
      inject(A_WAIT, 1'b0, 16'h0004);
    join
    chk(ldd && gp == vec_of(2), "R9 merged pulse chosen", {ldd, 15'd0, gp}, {16'h8000, vec_of(2)});
    chk(ln == 5 && ldat[4] == 16'h0100, "R9 remaining parked", {8'(ln), 8'd0, ldat[4]}, {8'd5, 8'd0, 16'h0100});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule